// File: doc/BRIEF.md
# Prefix-Header Instruction Block Splitter

This block takes fixed 256-bit code blocks and breaks each one into individual instructions for a downstream decoder. A block may begin with a 32-bit header. The header is a four-bit tag of all ones followed by fourteen two-bit prefix codes. Each prefix code describes one 16-bit slot of the 224-bit payload that follows the header. A prefix either marks a 17-bit short instruction, where the prefix supplies the extra leading bit, or opens a long instruction. It can also extend the long instruction that is currently open by one more slot. The block finds the instruction boundaries from the header alone, without looking at the instruction bits.

A block is accepted on a valid/ready input. The instructions of that block are then presented one per cycle, in slot order, on a valid/ready output. Each output carries the left-justified instruction bits, its length in 16-bit slots and a short-instruction flag. A block whose tag is not all ones is not parsed. It leaves as one output that carries all 256 bits and is marked raw. An extension prefix with no open instruction is a malformed header. That slot is discarded and an error pulse is raised.

Top module: `instr_block_splitter`

## Requirements
- R1: While reset is asserted and after it is released, out_valid and out_err are low. in_ready is high once the internal reset release has completed, within three clock cycles of rst_n rising.
- R2: A block is headered when in_block[255:252] equals 4'b1111. Any other tag produces exactly one output with out_raw=1, out_data equal to the whole 256-bit block, out_len=0 and out_short=0.
- R3: The prefix for slot i sits at in_block[251-2i -: 2], and slot i sits at in_block[223-16i -: 16], for i from 0 to 13. Slot 0 is the most significant.
- R4: Prefix 2'b00 or 2'b01 yields a short instruction: out_short=1, out_len=1, out_data[255:239] = {prefix bit 0, slot bits}, and all other bits of out_data are zero.
- R5: Prefix 2'b10 opens a long instruction. Each directly following slot with prefix 2'b11 is appended below it. out_data holds the slots left-justified from bit 255 with zeros below, out_short=0, and out_len is the slot count.
- R6: Instructions leave in increasing slot order, one per cycle. While out_valid is high and out_ready is low, all output fields hold steady.
- R7: A 2'b11 prefix with no open instruction is an orphan. This happens in slot 0, after a short instruction or after another orphan. The orphan slot produces no output, and out_err pulses high in the cycle after the block is accepted.
- R8: in_ready is low while any instruction of the held block is still pending. It is high in the cycle after the last one is taken, or directly after a block that yields no instruction.
- R9: A long instruction ends at the next slot whose prefix is 2'b00, 2'b01 or 2'b10, or at slot 13. Its length can reach 14 slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A code block is offered |
| in_ready | output | 1 | The splitter can take a new block |
| in_block | input | 256 | Code block, tag in the top bits |
| out_valid | output | 1 | An instruction is presented |
| out_ready | input | 1 | Downstream takes the instruction |
| out_data | output | 256 | Left-justified instruction bits, or the raw block |
| out_len | output | 4 | Length in 16-bit slots, 0 for raw |
| out_short | output | 1 | Output is a 17-bit short instruction |
| out_raw | output | 1 | Output is an unparsed block without the header |
| out_err | output | 1 | One-cycle pulse: the accepted header held an orphan extension |

## Verification
The assertions assume that downstream obeys the valid/ready rule. They also assume that out_ready is the only thing that lets a presented instruction go. Under those assumptions, an output must not change while it is stalled, and in_ready must never overlap a pending output. The stimulus drives in_valid for exactly one accepting edge at a time and raises it only when in_ready is high. It changes out_ready only between edges, so every stall and release is a clean handshake. The headers used cover all-short, a single 14-slot instruction, mixed lengths, scattered orphans, all orphans, two non-matching tags and several random prefix patterns, with and without stalls.

// File: rtl/isb_pkg.sv
package isb_pkg;

  localparam int unsigned DEF_SLOTS  = 14;
  localparam int unsigned DEF_SLOT_W = 16;
  localparam int unsigned DEF_TAG_W  = 4;
  localparam int unsigned PFX_W      = 2;

  // Per-slot prefix code; the values are fixed by the header format.
  typedef enum logic [1:0] {
    PFX_SHORT_LO = 2'b00,
    PFX_SHORT_HI = 2'b01,
    PFX_OPEN     = 2'b10,
    PFX_APPEND   = 2'b11
  } pfx_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EMIT = 1'b1
  } split_state_e;

endpackage

// File: rtl/isb_rst_sync.sv
module isb_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic stage_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      stage_q <= 1'b0;
      sync_q  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      sync_q  <= stage_q;
    end
  end

  assign rst_n_sync = sync_q;

endmodule

// File: rtl/isb_prefix_decode.sv
module isb_prefix_decode
  import isb_pkg::*;
#(
  parameter int unsigned SLOTS = DEF_SLOTS,
  parameter int unsigned LEN_W = $clog2(SLOTS + 1)
) (
  input  logic [PFX_W*SLOTS-1:0] pfx_bus,
  output logic [SLOTS-1:0]       start_mask,
  output logic [SLOTS-1:0]       short_mask,
  output logic [SLOTS-1:0]       short_msb,
  output logic [SLOTS-1:0]       orphan_mask,
  output logic [SLOTS*LEN_W-1:0] len_bus
);

  // open_c[i]: an instruction is open when slot i is reached.
  logic [SLOTS-1:0] open_c;
  logic [SLOTS-1:0] cont;
  // run[i]: number of consecutive appended slots starting at slot i.
  logic [LEN_W-1:0] run [1:SLOTS];

  assign open_c[0]  = 1'b0;
  assign run[SLOTS] = '0;

  for (genvar gi = 0; gi < SLOTS; gi++) begin : g_slot
    pfx_e code;
    assign code = pfx_e'(pfx_bus[PFX_W*(SLOTS-gi)-1 -: PFX_W]);

    assign cont[gi]        = (code == PFX_APPEND) &  open_c[gi];
    assign orphan_mask[gi] = (code == PFX_APPEND) & ~open_c[gi];
    assign start_mask[gi]  = (code != PFX_APPEND);
    assign short_mask[gi]  = (code == PFX_SHORT_LO) | (code == PFX_SHORT_HI);
    assign short_msb[gi]   = (code == PFX_SHORT_HI);

    if (gi < SLOTS - 1) begin : g_chain
      assign open_c[gi+1] = (code == PFX_OPEN) | cont[gi];
    end

    if (gi > 0) begin : g_run
      assign run[gi] = cont[gi] ? (run[gi+1] + LEN_W'(1)) : '0;
    end

    assign len_bus[gi*LEN_W +: LEN_W] = run[gi+1] + LEN_W'(1);
  end

endmodule

// File: rtl/isb_slot_pick.sv
module isb_slot_pick #(
  parameter int unsigned SLOTS = 14,
  parameter int unsigned IDX_W = $clog2(SLOTS)
) (
  input  logic [SLOTS-1:0] pending,
  output logic [SLOTS-1:0] first_oh,
  output logic [IDX_W-1:0] first_idx
);

  // Lowest set bit is the earliest pending slot.
  assign first_oh = pending & (~pending + SLOTS'(1));

  always_comb begin
    first_idx = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (first_oh[i]) first_idx = first_idx | IDX_W'(i);
    end
  end

endmodule

// File: rtl/isb_slot_extract.sv
module isb_slot_extract #(
  parameter int unsigned SLOTS  = 14,
  parameter int unsigned SLOT_W = 16,
  parameter int unsigned LEN_W  = $clog2(SLOTS + 1),
  parameter int unsigned IDX_W  = $clog2(SLOTS),
  parameter int unsigned PAY_W  = SLOTS * SLOT_W
) (
  input  logic [PAY_W-1:0] payload,
  input  logic [IDX_W-1:0] idx,
  input  logic [LEN_W-1:0] len,
  input  logic             is_short,
  input  logic             short_msb,
  output logic [PAY_W-1:0] field
);

  localparam int unsigned SH_W = $clog2(PAY_W) + 1;

  logic [SH_W-1:0]  sh_lead;
  logic [SH_W-1:0]  sh_keep;
  logic [PAY_W-1:0] aligned;
  logic [PAY_W-1:0] keep_mask;

  assign sh_lead   = SH_W'(idx) * SH_W'(SLOT_W);
  assign sh_keep   = SH_W'(len) * SH_W'(SLOT_W);
  assign aligned   = payload << sh_lead;
  assign keep_mask = ~({PAY_W{1'b1}} >> sh_keep);

  always_comb begin
    field = '0;
    if (is_short) begin
      field[PAY_W-1 -: SLOT_W+1] = {short_msb, aligned[PAY_W-1 -: SLOT_W]};
    end else begin
      field = aligned & keep_mask;
    end
  end

endmodule

// File: rtl/instr_block_splitter.sv
module instr_block_splitter
  import isb_pkg::*;
#(
  parameter  int unsigned SLOTS  = DEF_SLOTS,
  parameter  int unsigned SLOT_W = DEF_SLOT_W,
  parameter  int unsigned TAG_W  = DEF_TAG_W,
  localparam int unsigned HDR_W  = TAG_W + PFX_W * SLOTS,
  localparam int unsigned PAY_W  = SLOTS * SLOT_W,
  localparam int unsigned BLK_W  = HDR_W + PAY_W,
  localparam int unsigned LEN_W  = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [BLK_W-1:0] in_block,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [BLK_W-1:0] out_data,
  output logic [LEN_W-1:0] out_len,
  output logic             out_short,
  output logic             out_raw,
  output logic             out_err
);

  localparam int unsigned IDX_W = $clog2(SLOTS);
  localparam int unsigned PFX_TOT = PFX_W * SLOTS;

  logic rst_n_q;

  isb_rst_sync u_rst_sync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_q)
  );

  split_state_e     state_q, state_d;
  logic [BLK_W-1:0] blk_q;
  logic             blk_en;
  logic [SLOTS-1:0] pend_q, pend_d;
  logic             raw_q, raw_d;
  logic             err_q, err_d;

  logic             accept;
  logic             fire;
  logic             tag_hit;
  logic [PFX_TOT-1:0] pfx_src;

  logic [SLOTS-1:0]       start_mask;
  logic [SLOTS-1:0]       short_mask;
  logic [SLOTS-1:0]       short_msb;
  logic [SLOTS-1:0]       orphan_mask;
  logic [SLOTS*LEN_W-1:0] len_bus;

  logic [SLOTS-1:0] first_oh;
  logic [IDX_W-1:0] first_idx;
  logic [SLOTS-1:0] pend_left;
  logic [LEN_W-1:0] sel_len;
  logic [PAY_W-1:0] field;

  // While idle the incoming header is decoded to seed the walk; while
  // emitting the held header supplies lengths and short bits.
  assign pfx_src = (state_q == ST_IDLE) ? in_block[BLK_W-TAG_W-1 -: PFX_TOT]
                                        : blk_q[BLK_W-TAG_W-1 -: PFX_TOT];
  assign tag_hit = &in_block[BLK_W-1 -: TAG_W];

  isb_prefix_decode #(
    .SLOTS (SLOTS),
    .LEN_W (LEN_W)
  ) u_decode (
    .pfx_bus     (pfx_src),
    .start_mask  (start_mask),
    .short_mask  (short_mask),
    .short_msb   (short_msb),
    .orphan_mask (orphan_mask),
    .len_bus     (len_bus)
  );

  isb_slot_pick #(
    .SLOTS (SLOTS),
    .IDX_W (IDX_W)
  ) u_pick (
    .pending   (pend_q),
    .first_oh  (first_oh),
    .first_idx (first_idx)
  );

  assign sel_len   = len_bus[int'(first_idx)*LEN_W +: LEN_W];
  assign pend_left = pend_q & ~first_oh;

  isb_slot_extract #(
    .SLOTS  (SLOTS),
    .SLOT_W (SLOT_W),
    .LEN_W  (LEN_W),
    .IDX_W  (IDX_W),
    .PAY_W  (PAY_W)
  ) u_extract (
    .payload   (blk_q[PAY_W-1:0]),
    .idx       (first_idx),
    .len       (sel_len),
    .is_short  (short_mask[first_idx]),
    .short_msb (short_msb[first_idx]),
    .field     (field)
  );

  assign in_ready  = rst_n_q & (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_EMIT);
  assign accept    = in_valid & in_ready;
  assign fire      = out_valid & out_ready;

  // Next-state process
  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    raw_d   = raw_q;
    err_d   = 1'b0;
    blk_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          blk_en = 1'b1;
          if (tag_hit) begin
            raw_d   = 1'b0;
            pend_d  = start_mask;
            err_d   = |orphan_mask;
            state_d = (|start_mask) ? ST_EMIT : ST_IDLE;
          end else begin
            raw_d   = 1'b1;
            pend_d  = '0;
            state_d = ST_EMIT;
          end
        end
      end
      ST_EMIT: begin
        if (fire) begin
          if (raw_q) begin
            state_d = ST_IDLE;
          end else begin
            pend_d = pend_left;
            if (pend_left == '0) state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      raw_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      raw_q   <= raw_d;
      err_q   <= err_d;
    end
  end

  // Block holding register: datapath, no reset, explicit enable
  always_ff @(posedge clk) begin
    if (blk_en) blk_q <= in_block;
  end

  assign out_data  = raw_q ? blk_q : {field, {HDR_W{1'b0}}};
  assign out_len   = raw_q ? '0 : sel_len;
  assign out_short = ~raw_q & short_mask[first_idx];
  assign out_raw   = raw_q;
  assign out_err   = err_q;

endmodule

// File: rtl/isb_splitter_chk.sv
module isb_splitter_chk #(
  parameter int unsigned BLK_W = 256,
  parameter int unsigned LEN_W = 4,
  parameter int unsigned SLOTS = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [BLK_W-1:0] out_data,
  input logic [LEN_W-1:0] out_len,
  input logic             out_short,
  input logic             out_raw,
  input logic             out_err
);

  // R6: a stalled output keeps every field
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
      $stable(out_len) && $stable(out_short) && $stable(out_raw)));

  // R8: no new block while an instruction is pending
  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R4: short instructions always span one slot
  assert_short_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_short) |-> (out_len == LEN_W'(1)));

  // R2: raw outputs carry no length and no short flag
  assert_raw_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_raw) |-> (out_len == '0 && !out_short));

  // R5, R9: parsed lengths stay inside the block
  assert_len_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_raw) |-> (out_len >= LEN_W'(1) && out_len <= LEN_W'(SLOTS)));

  // R7: the error pulse only follows an accepted block
  assert_err_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> $past(in_valid && in_ready));

endmodule

bind instr_block_splitter isb_splitter_chk #(
  .BLK_W (BLK_W),
  .LEN_W (LEN_W),
  .SLOTS (SLOTS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_len   (out_len),
  .out_short (out_short),
  .out_raw   (out_raw),
  .out_err   (out_err)
);

// File: tb/instr_block_splitter_tb.sv
module instr_block_splitter_tb;

  localparam int CLK_PERIOD = 10;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [255:0] in_block;
  logic         out_valid;
  logic         out_ready;
  logic [255:0] out_data;
  logic [3:0]   out_len;
  logic         out_short;
  logic         out_raw;
  logic         out_err;

  int n_chk  = 0;
  int n_fail = 0;

  logic [255:0] e_data  [14];
  logic [3:0]   e_len   [14];
  logic         e_short [14];
  int           e_n;
  logic         e_err;
  logic         e_raw;

  instr_block_splitter u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_block  (in_block),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_len   (out_len),
    .out_short (out_short),
    .out_raw   (out_raw),
    .out_err   (out_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string msg, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", msg, act, exp);
    end
  endtask

  function automatic logic [255:0] mk_hdr(input logic [27:0] pfx, input logic [7:0] seed);
    logic [223:0] p;
    for (int i = 0; i < 14; i++) p[223-16*i -: 16] = {seed, 4'(i), ~4'(i)};
    return {4'hF, pfx, p};
  endfunction

  // Expected outputs derived from R2..R9
  task automatic model(input logic [255:0] b);
    logic open_f;
    e_n = 0; e_err = 1'b0; e_raw = 1'b0;
    if (b[255:252] != 4'hF) begin
      e_raw = 1'b1; e_n = 1;
      e_data[0] = b; e_len[0] = 4'd0; e_short[0] = 1'b0;
    end else begin
      open_f = 1'b0;
      for (int i = 0; i < 14; i++) begin
        logic [1:0]  p;
        logic [15:0] s;
        p = b[251-2*i -: 2];
        s = b[223-16*i -: 16];
        if (p[1] == 1'b0) begin
          e_data[e_n] = '0; e_data[e_n][255 -: 17] = {p[0], s};
          e_len[e_n] = 4'd1; e_short[e_n] = 1'b1; e_n++; open_f = 1'b0;
        end else if (p == 2'b10) begin
          e_data[e_n] = '0; e_data[e_n][255 -: 16] = s;
          e_len[e_n] = 4'd1; e_short[e_n] = 1'b0; e_n++; open_f = 1'b1;
        end else if (open_f) begin
          e_data[e_n-1][255-16*int'(e_len[e_n-1]) -: 16] = s;
          e_len[e_n-1] = e_len[e_n-1] + 4'd1;
        end else begin
          e_err = 1'b1;
        end
      end
    end
  endtask

  task automatic run_block(input string tag, input logic [255:0] b, input int stall);
    model(b);
    @(negedge clk);
    check({tag, " R8 in_ready before accept"}, 256'(in_ready), 256'(1));
    in_valid = 1'b1;
    in_block = b;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " R7 error pulse"}, 256'(out_err), 256'(e_err));
    for (int k = 0; k < e_n; k++) begin
      int    hold;
      string rq;
      hold = (stall != 0 && (k % stall) == 0) ? 2 : 0;
      rq = e_raw ? "R2" : (e_short[k] ? "R4" : "R5");
      out_ready = 1'b0;
      for (int h = 0; h < hold; h++) begin
        check({tag, " R6 stalled data"}, out_data, e_data[k]);
        check({tag, " R6 stalled valid/len"}, 256'({out_valid, out_len}), 256'({1'b1, e_len[k]}));
        @(negedge clk);
      end
      out_ready = 1'b1;
      check({tag, " ", rq, " R3 R6 data"}, out_data, e_data[k]);
      check({tag, " ", rq, " R9 valid/raw/short/len"},
            256'({out_valid, out_raw, out_short, out_len}),
            256'({1'b1, e_raw, e_short[k], e_len[k]}));
      check({tag, " R8 in_ready low while pending"}, 256'(in_ready), 256'(0));
      @(negedge clk);
    end
    out_ready = 1'b0;
    check({tag, " R6 R7 no extra output"}, 256'(out_valid), 256'(0));
    check({tag, " R8 in_ready after last"}, 256'(in_ready), 256'(1));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_block = '0;
    repeat (3) @(negedge clk);
    check("R1 reset out_valid", 256'(out_valid), 256'(0));
    check("R1 reset out_err", 256'(out_err), 256'(0));
    check("R1 reset in_ready", 256'(in_ready), 256'(0));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 post-reset in_ready", 256'(in_ready), 256'(1));
    check("R1 post-reset out_valid", 256'(out_valid), 256'(0));
  endtask

  task automatic t_raw();
    run_block("R2 tag 1110", {4'hE, 252'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210_0F0F_F0F0_A5A5_5A5A_C3C3_3C3C_1}, 0);
    run_block("R2 tag 0111", {4'h7, 252'hF}, 1);
  endtask

  task automatic t_all_short();
    run_block("R3 R4 all short", mk_hdr(28'h1111111, 8'h5A), 0);
  endtask

  task automatic t_full_long();
    run_block("R5 R9 fourteen slots", mk_hdr(28'hBFFFFFF, 8'hC3), 0);
  endtask

  task automatic t_mixed();
    run_block("R5 R9 mixed", mk_hdr(28'hBCAD2FD, 8'h11), 0);
  endtask

  task automatic t_orphans();
    run_block("R7 scattered orphans", mk_hdr(28'hDECFAF3, 8'h77), 0);
    run_block("R7 R8 all orphans", mk_hdr(28'hFFFFFFF, 8'h99), 0);
  endtask

  task automatic t_backpressure();
    run_block("R6 stall mixed", mk_hdr(28'hBCAD2FD, 8'h42), 1);
    run_block("R6 stall orphans", mk_hdr(28'hDECFAF3, 8'h24), 2);
  endtask

  task automatic t_random();
    for (int r = 0; r < 8; r++) begin
      logic [255:0] b;
      for (int w = 0; w < 8; w++) b[32*w +: 32] = $urandom;
      b[255:252] = 4'hF;
      run_block("R5 R7 R9 random", b, r % 3);
    end
  endtask

  initial begin
    t_reset();
    t_raw();
    t_all_short();
    t_full_long();
    t_mixed();
    t_orphans();
    t_backpressure();
    t_random();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule